// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slow divided clock from a fast reference clock. Its plain setting divides the reference by one programmable integer. In its alternating setting it uses two integer divisors in turn. A repetition count for each divisor sets how many output periods that divisor lasts before the other one takes over. The average over a whole sequence is a fractional ratio. This is how an accurate low-frequency clock, such as a 32.768 kHz sleep clock, is obtained from a reference that does not divide down to it evenly.

Every configuration field holds the wanted value minus one. The fields are taken into working copies only at the end of a whole sequence, so a change made while the divider runs never cuts a period short. A one-cycle strobe marks the last reference cycle of every output period.

Top module: `dualmod_clkdiv`

## Requirements
- R1: With `cfg_dual` low, every output period lasts `cfg_n1`+1 reference cycles, and `period_tick` pulses once per period.
- R2: With `cfg_dual` low, the values on `cfg_n2`, `cfg_m1` and `cfg_m2` have no effect on the period lengths or on `div_out`.
- R3: With `cfg_dual` high, the divider runs `cfg_m1`+1 periods of `cfg_n1`+1 cycles, then `cfg_m2`+1 periods of `cfg_n2`+1 cycles, and then repeats.
- R4: In the alternating setting, one full sequence spans exactly (`cfg_n1`+1)(`cfg_m1`+1) + (`cfg_n2`+1)(`cfg_m2`+1) reference cycles. The average output frequency is therefore f_ref·(m1+m2)/(n1·m1+n2·m2) in effective values.
- R5: In a period of N cycles, `div_out` is high for the first floor(N/2) cycles and low for the rest. When N is 1, `div_out` stays high.
- R6: `period_tick` is high for exactly one cycle, the last cycle of each output period.
- R7: Configuration inputs are sampled only where a full sequence ends (each period end in the plain setting). Periods still pending in the running sequence keep the old values.
- R8: While `rst_n` is low, `div_out` and `period_tick` are low. After release, the first rising edge loads the configuration in phase one with the counters cleared, and the first `period_tick` follows cfg_n1+1 edges later.
- R9: A field at its all-ones value (4095 at the default 12-bit width) gives an effective divisor of 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1 = alternate two divisors, 0 = single divisor |
| cfg_n1 | input | DIV_W | First divisor minus one |
| cfg_n2 | input | DIV_W | Second divisor minus one |
| cfg_m1 | input | REP_W | Periods spent on the first divisor, minus one |
| cfg_m2 | input | REP_W | Periods spent on the second divisor, minus one |
| div_out | output | 1 | Divided clock, about 50% duty |
| period_tick | output | 1 | One-cycle strobe on the last cycle of each period |

## Verification
The hardest state to reach from the ports is a configuration write that lands partway through the second divisor's run, where the old fields must still govern the periods that remain. The stimulus resets into a known alternating pattern and counts strobes until the second divisor is active. It then writes a different single-divisor setting right after a strobe and checks that the leftover periods keep the old length before the new one appears. Period lengths and high counts are measured strobe to strobe, so the alternation order and the duty rule are both checked.

// File: rtl/dmd_pkg.sv
`timescale 1ns/1ps
package dmd_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/dmd_seq.sv
`timescale 1ns/1ps
// Sequencer: working copy of the configuration, phase and repetition count.
module dmd_seq #(
  parameter int DIV_W = 12,
  parameter int REP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [DIV_W-1:0] cfg_n1,
  input  logic [DIV_W-1:0] cfg_n2,
  input  logic [REP_W-1:0] cfg_m1,
  input  logic [REP_W-1:0] cfg_m2,
  input  logic             period_end,
  output logic             run,
  output logic [DIV_W-1:0] n_cur
);
  import dmd_pkg::*;

  logic             run_q;
  logic             sh_dual_q, sh_dual_d;
  logic [DIV_W-1:0] sh_n1_q, sh_n1_d, sh_n2_q, sh_n2_d;
  logic [REP_W-1:0] sh_m1_q, sh_m1_d, sh_m2_q, sh_m2_d;
  phase_e           phase_q, phase_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [REP_W-1:0] m_cur;
  logic             rep_end, seq_end, load, upd_en;

  always_comb begin
    m_cur   = (phase_q == PH_B) ? sh_m2_q : sh_m1_q;
    rep_end = (rep_q == m_cur);
    seq_end = period_end && (!sh_dual_q || ((phase_q == PH_B) && rep_end));
    load    = !run_q || seq_end;
    upd_en  = load || period_end;

    sh_dual_d = sh_dual_q;
    sh_n1_d   = sh_n1_q;
    sh_n2_d   = sh_n2_q;
    sh_m1_d   = sh_m1_q;
    sh_m2_d   = sh_m2_q;
    phase_d   = phase_q;
    rep_d     = rep_q;
    if (load) begin
      sh_dual_d = cfg_dual;
      sh_n1_d   = cfg_n1;
      sh_n2_d   = cfg_n2;
      sh_m1_d   = cfg_m1;
      sh_m2_d   = cfg_m2;
      phase_d   = PH_A;
      rep_d     = '0;
    end else if (rep_end) begin
      phase_d = (phase_q == PH_A) ? PH_B : PH_A;
      rep_d   = '0;
    end else begin
      rep_d = rep_q + REP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      sh_dual_q <= 1'b0;
      sh_n1_q   <= '0;
      sh_n2_q   <= '0;
      sh_m1_q   <= '0;
      sh_m2_q   <= '0;
      phase_q   <= PH_A;
      rep_q     <= '0;
    end else begin
      run_q <= 1'b1;
      if (upd_en) begin
        sh_dual_q <= sh_dual_d;
        sh_n1_q   <= sh_n1_d;
        sh_n2_q   <= sh_n2_d;
        sh_m1_q   <= sh_m1_d;
        sh_m2_q   <= sh_m2_d;
        phase_q   <= phase_d;
        rep_q     <= rep_d;
      end
    end
  end

  assign run   = run_q;
  assign n_cur = (phase_q == PH_B) ? sh_n2_q : sh_n1_q;

  // R3: repetition count never passes the active limit
  p_rep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rep_q <= m_cur));
  // R2: single setting never leaves the first phase
  p_single_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sh_dual_q) |-> (phase_q == PH_A));
  // R7: working copy only changes at a sequence end
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !seq_end) |=> ($stable(sh_n1_q) && $stable(sh_n2_q) &&
                             $stable(sh_m1_q) && $stable(sh_m2_q) &&
                             $stable(sh_dual_q)));
endmodule

// File: rtl/dmd_cnt.sv
`timescale 1ns/1ps
// Reference-cycle counter within one output period, with duty compare.
module dmd_cnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] n_cur,
  output logic             period_end,
  output logic             hi_now
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] cyc_q, cyc_d;
  logic [CW-1:0]    n_eff, hi_len;

  always_comb begin
    period_end = run && (cyc_q == n_cur);
    cyc_d      = period_end ? '0 : (cyc_q + DIV_W'(1));
    n_eff      = {1'b0, n_cur} + CW'(1);
    hi_len     = (n_cur == '0) ? CW'(1) : (n_eff >> 1);
    hi_now     = run && ({1'b0, cyc_q} < hi_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (run) begin
      cyc_q <= cyc_d;
    end
  end

  // R1: in-period count stays inside the active divisor
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc_q <= n_cur));
endmodule

// File: rtl/dualmod_clkdiv.sv
`timescale 1ns/1ps
module dualmod_clkdiv #(
  parameter int DIV_W = 12,
  parameter int REP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [DIV_W-1:0] cfg_n1,
  input  logic [DIV_W-1:0] cfg_n2,
  input  logic [REP_W-1:0] cfg_m1,
  input  logic [REP_W-1:0] cfg_m2,
  output logic             div_out,
  output logic             period_tick
);
  logic             run, period_end, hi_now;
  logic [DIV_W-1:0] n_cur;
  logic             out_q, out_d, tick_q, tick_d;

  dmd_seq #(.DIV_W(DIV_W), .REP_W(REP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dual   (cfg_dual),
    .cfg_n1     (cfg_n1),
    .cfg_n2     (cfg_n2),
    .cfg_m1     (cfg_m1),
    .cfg_m2     (cfg_m2),
    .period_end (period_end),
    .run        (run),
    .n_cur      (n_cur)
  );

  dmd_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .n_cur      (n_cur),
    .period_end (period_end),
    .hi_now     (hi_now)
  );

  always_comb begin
    out_d  = hi_now;
    tick_d = period_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      tick_q <= tick_d;
    end
  end

  assign div_out     = out_q;
  assign period_tick = tick_q;

  // R8: outputs stay quiet on the configuration-load edge
  p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!period_tick && !div_out));
  // R5: last cycle of a period longer than one is low
  p_last_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && (n_cur != '0)) |-> !hi_now);
endmodule

// File: tb/dualmod_clkdiv_bench.sv
`timescale 1ns/1ps
module dualmod_clkdiv_bench;
  localparam int DW = 12;
  localparam int MW = 12;
  localparam int NV = 6;
  localparam int NP = 12;
  // columns: dual, n1, n2, m1, m2 (register values, effective = value+1)
  localparam int VEC [0:NV-1][0:4] = '{
    '{0, 0,   0,   0,   0},
    '{0, 1,   0,   0,   0},
    '{0, 6, 100, 333, 7},
    '{1, 2,   3,   0,   0},
    '{1, 4,   5,   2,   1},
    '{1, 0,   1,   1,   2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0;
  logic [DW-1:0] cfg_n1 = '0, cfg_n2 = '0;
  logic [MW-1:0] cfg_m1 = '0, cfg_m2 = '0;
  logic div_out, period_tick;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dualmod_clkdiv #(.DIV_W(DW), .REP_W(MW)) u_dualmod_clkdiv (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .cfg_n1(cfg_n1), .cfg_n2(cfg_n2), .cfg_m1(cfg_m1), .cfg_m2(cfg_m2),
    .div_out(div_out), .period_tick(period_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int d, int n1, int n2, int m1, int m2, int idx);
    int l, j;
    if (d == 0) return n1 + 1;
    l = m1 + m2 + 2;
    j = idx % l;
    return (j < m1 + 1) ? n1 + 1 : n2 + 1;
  endfunction

  function automatic int exp_hi(int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  task automatic measure(output int len, output int hi);
    len = 0;
    hi = 0;
    do begin
      @(negedge clk);
      len++;
      if (div_out) hi++;
    end while (!period_tick && len < 20000);
  endtask

  task automatic do_reset(input int d, input int n1, input int n2, input int m1, input int m2);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_dual = d[0];
    cfg_n1 = DW'(n1);
    cfg_n2 = DW'(n2);
    cfg_m1 = MW'(m1);
    cfg_m2 = MW'(m2);
    repeat (3) @(negedge clk);
    chk("R8 div_out low in reset", int'(div_out), 0);
    chk("R8 period_tick low in reset", int'(period_tick), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int len, hi, sum, l, e;
    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      measure(len, hi);
      chk("R8 first strobe delay", len, VEC[v][1] + 2);
      l = VEC[v][3] + VEC[v][4] + 2;
      sum = 0;
      for (int p = 1; p <= NP; p++) begin
        measure(len, hi);
        e = exp_len(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], p);
        if (VEC[v][0] != 0) chk("R3 R6 period length", len, e);
        else if (v == 2)    chk("R2 R6 period length", len, e);
        else                chk("R1 R6 period length", len, e);
        chk("R5 high cycles", hi, exp_hi(e));
        if (p >= l && p < 2 * l) sum += len;
      end
      if (VEC[v][0] != 0)
        chk("R4 sequence span", sum,
            (VEC[v][1] + 1) * (VEC[v][3] + 1) + (VEC[v][2] + 1) * (VEC[v][4] + 1));
    end

    // R7: mid-sequence write keeps the old sequence until its end
    do_reset(1, 1, 2, 1, 1);
    measure(len, hi);
    measure(len, hi);
    chk("R7 old first phase", len, 2);
    cfg_dual = 1'b0;
    cfg_n1 = DW'(4);
    measure(len, hi);
    chk("R7 old second phase a", len, 3);
    measure(len, hi);
    chk("R7 old second phase b", len, 3);
    for (int p = 0; p < 3; p++) begin
      measure(len, hi);
      chk("R7 new setting period", len, 5);
      chk("R5 high cycles new setting", hi, 2);
    end

    // R9: all-ones field value
    do_reset(0, 4095, 0, 0, 0);
    measure(len, hi);
    measure(len, hi);
    chk("R9 max divisor period", len, 4096);
    chk("R9 max divisor high", hi, 2048);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule